// File: doc/BRIEF.md
# Segmented DAC Switch-Control Decoder

This block turns a binary DAC code into the switch-enable lines of a segmented current-steering DAC. The code is cut into two fields. The upper field goes through a thermometer encoder. Each of its output lines enables one identical unit current source, so the count of enabled units equals the field's value. The lower field is not decoded. Its bits drive binary-weighted current sources directly.

The thermometer encoder is built as a chain of growth stages. A single code bit starts the chain as a one-line thermometer. Each stage then takes the next more significant bit, called the stage bit here. The stage keeps the previous thermometer and ORs the stage bit into it to form the low half. The stage bit alone is the middle line. The stage bit ANDed with the previous thermometer forms the high half. One stage therefore turns 2 bits into 3 lines, the next turns 3 bits into 7 lines, and so on.

All thermometer and binary lines are captured in one register on the same clock edge. Every current source therefore switches in the same cycle. An asynchronous active-low reset turns every source off.

Top module: `seg_dac_switch_dec`

## Requirements
- R1: The input code `code_i` is split into an upper field `code_i[7:4]` and a lower field `code_i[3:0]` (default parameters). The upper field is thermometer-encoded and the lower field is binary-coded.
- R2: Thermometer line `therm_o[k]` (k = 0 to 14) is 1 exactly when the upper field, read as an unsigned number, is greater than k.
- R3: The asserted thermometer lines always form one contiguous run that starts at bit 0, with no gaps.
- R4: Output `bin_o[i]` equals code bit `code_i[i]` for i = 0 to 3, with no decoding.
- R5: A code present at a rising clock edge appears on both output groups immediately after that edge. Both groups update on the same edge, with a latency of one register.
- R6: While `rst_n` is low, every thermometer line and every binary line is 0.
- R7: For every code, 16 times the number of asserted thermometer lines plus the value of `bin_o` equals the code that was registered.
- R8: While the code input is held constant, the outputs do not change from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | 8 | Binary DAC code |
| therm_o | output | 15 | Registered unit-source enables, in thermometer code |
| bin_o | output | 4 | Registered binary-weighted source enables |

## Verification
Every output is due exactly one rising edge after its code is presented, because the encoder is combinational and feeds a single register. The bench therefore changes the code on a falling edge and samples both groups on the next falling edge. By then exactly one rising edge has captured the code, and no further edge has passed. The sweep runs through all 256 codes upward, then downward, then in a stride that jumps across distant codes. In each case the thermometer pattern, the binary field, the contiguity and the weighted sum are recomputed from the code alone. The reset check samples on a falling edge while reset is held, and a hold check samples two falling edges apart under a constant code.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

  // Number of thermometer lines produced from a field of the given width.
  function automatic int unsigned therm_lines(input int unsigned bits);
    return (1 << bits) - 1;
  endfunction

  // Weight that one unit source carries, measured in binary LSB sources.
  function automatic int unsigned unit_weight(input int unsigned lo_bits);
    return 1 << lo_bits;
  endfunction

endpackage

// File: rtl/seg_therm_grow.sv
// One growth stage: a thermometer of LO_W lines plus a new stage bit
// becomes a thermometer of 2*LO_W+1 lines.
module seg_therm_grow #(
  parameter int unsigned LO_W = 1
) (
  input  logic [LO_W-1:0] lo_t,
  input  logic            msb,
  output logic [2*LO_W:0] t
);

  for (genvar k = 0; k < LO_W; k++) begin : g_line
    assign t[k]          = msb | lo_t[k];
    assign t[LO_W+1+k]   = msb & lo_t[k];
  end
  assign t[LO_W] = msb;

endmodule

// File: rtl/seg_therm_enc.sv
// Thermometer encoder grown stage by stage from the least significant bit.
module seg_therm_enc #(
  parameter int unsigned BITS = 4,
  localparam int unsigned TW  = (1 << BITS) - 1
) (
  input  logic [BITS-1:0] bin,
  output logic [TW-1:0]   therm
);

  for (genvar l = 0; l < BITS; l++) begin : g_lvl
    logic [(1 << (l+1)) - 2:0] t;
    if (l == 0) begin : g_seed
      assign t = bin[0];
    end else begin : g_stage
      seg_therm_grow #(.LO_W((1 << l) - 1)) u_grow (
        .lo_t (g_lvl[l-1].t),
        .msb  (bin[l]),
        .t    (t)
      );
    end
  end

  assign therm = g_lvl[BITS-1].t;

endmodule

// File: rtl/seg_switch_reg.sv
// Single register stage for all switch lines.
module seg_switch_reg #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/seg_dac_switch_dec.sv
module seg_dac_switch_dec #(
  parameter int unsigned HI_BITS = 4,
  parameter int unsigned LO_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [HI_BITS+LO_BITS-1:0]    code_i,
  output logic [(1 << HI_BITS)-2:0]     therm_o,
  output logic [LO_BITS-1:0]            bin_o
);

  localparam int unsigned TW    = seg_dac_pkg::therm_lines(HI_BITS);
  localparam int unsigned REG_W = TW + LO_BITS;

  logic [HI_BITS-1:0] hi_field;
  logic [LO_BITS-1:0] lo_field;
  logic [TW-1:0]      therm_next;
  logic [LO_BITS-1:0] bin_next;
  logic [REG_W-1:0]   sw_q;

  assign hi_field = code_i[HI_BITS+LO_BITS-1:LO_BITS];
  assign lo_field = code_i[LO_BITS-1:0];
  assign bin_next = lo_field;

  seg_therm_enc #(.BITS(HI_BITS)) u_enc (
    .bin   (hi_field),
    .therm (therm_next)
  );

  seg_switch_reg #(.W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({therm_next, bin_next}),
    .q     (sw_q)
  );

  assign therm_o = sw_q[REG_W-1:LO_BITS];
  assign bin_o   = sw_q[LO_BITS-1:0];

endmodule

// File: rtl/seg_dac_switch_chk.sv
module seg_dac_switch_chk #(
  parameter int unsigned HI_BITS = 4,
  parameter int unsigned LO_BITS = 4,
  localparam int unsigned TW     = (1 << HI_BITS) - 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [HI_BITS+LO_BITS-1:0] code_i,
  input logic [TW-1:0]              therm_o,
  input logic [LO_BITS-1:0]         bin_o,
  input logic [TW-1:0]              therm_next
);

  logic [TW:0] out_fill;
  logic [TW:0] next_fill;
  always_comb begin
    out_fill  = ({{TW{1'b0}}, 1'b1} << $countones(therm_o)) - 1'b1;
    next_fill = ({{TW{1'b0}}, 1'b1} << $countones(therm_next)) - 1'b1;
  end

  assert_reset_off_R6: assert property (@(posedge clk)
    !rst_n |=> (therm_o == '0 && bin_o == '0));

  assert_contig_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, therm_o} == out_fill);

  assert_enc_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(therm_next) == code_i[HI_BITS+LO_BITS-1:LO_BITS])
    && ({1'b0, therm_next} == next_fill));

  assert_bin_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bin_o == $past(code_i[LO_BITS-1:0]));

  assert_same_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (therm_o == $past(therm_next)
              && bin_o == $past(code_i[LO_BITS-1:0])));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(code_i) |=> $stable(therm_o) && $stable(bin_o));

endmodule

bind seg_dac_switch_dec seg_dac_switch_chk #(
  .HI_BITS(HI_BITS),
  .LO_BITS(LO_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_i     (code_i),
  .therm_o    (therm_o),
  .bin_o      (bin_o),
  .therm_next (therm_next)
);

// File: tb/sim_seg_dac_switch_dec.sv
module sim_seg_dac_switch_dec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  code;
  logic [14:0] therm;
  logic [3:0]  bin;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  seg_dac_switch_dec u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (code),
    .therm_o (therm),
    .bin_o   (bin)
  );

  task automatic check(input bit ok, input string req,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Apply a code on a falling edge, then check it on the next falling edge.
  task automatic apply_and_check(input logic [7:0] c);
    int hi;
    int lo;
    int ones;
    int sum;
    logic [14:0] exp_t;
    logic [14:0] run;
    code = c;
    @(negedge clk);
    hi = int'(c) / 16;
    lo = int'(c) % 16;
    exp_t = '0;
    for (int k = 0; k < 15; k++) exp_t[k] = (hi > k);
    check(therm == exp_t, "R2/R1 therm", int'(therm), int'(exp_t));
    check(bin == 4'(lo), "R4/R1 bin", int'(bin), lo);
    ones = 0;
    for (int k = 0; k < 15; k++) ones += int'(therm[k]);
    run = '0;
    for (int k = 0; k < 15; k++) if (k < ones) run[k] = 1'b1;
    check(therm == run, "R3 contiguous", int'(therm), int'(run));
    sum = 16 * ones + int'(bin);
    check(sum == int'(c), "R7/R5 sum", sum, int'(c));
  endtask

  initial begin
    rst_n = 1'b0;
    code  = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check(therm == '0, "R6 therm reset", int'(therm), 0);
    check(bin == '0, "R6 bin reset", int'(bin), 0);
    rst_n = 1'b1;

    for (int c = 0; c < 256; c++) apply_and_check(8'(c));
    for (int c = 255; c >= 0; c--) apply_and_check(8'(c));
    for (int c = 0; c < 256; c++) apply_and_check(8'((c * 167 + 91) % 256));

    // R8: hold a code and confirm no change over further edges
    apply_and_check(8'h9C);
    @(negedge clk);
    check(therm == 15'h01FF, "R8 hold therm", int'(therm), 'h01FF);
    check(bin == 4'hC, "R8 hold bin", int'(bin), 'hC);

    // R6: reset mid-run with a full-scale code
    apply_and_check(8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    check(therm == '0, "R6 therm mid reset", int'(therm), 0);
    check(bin == '0, "R6 bin mid reset", int'(bin), 0);
    rst_n = 1'b1;
    apply_and_check(8'h7A);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule